// File: doc/BRIEF.md
# Burst Serializer Beam Controller

This block takes per-element phase and power commands from a slow host and plays them out to an array of transmit/receive modules over a fast serial bus. The host presents one command byte at a time on a valid/ready interface. Each byte is stored in an internal buffer as the command word for the next module in line. When the buffer holds a word for every module and a start request arrives, the block sends the whole buffer as one burst at the fast clock rate. It then clears the buffer so the next fill can begin.

For each module in turn, the block puts the module index on the address lines. It shifts the eight-bit word out on a single data line, timed by a gated serial clock, and then fires a one-cycle strobe. The strobe tells the addressed module to move the word into its phase and bias outputs. Each command byte carries the module's DC power enable in bit 7 and its encoded phase in bits 6:0.

Back-pressure rules on the host side: a byte moves only in a cycle where both `host_valid` and `host_ready` are high. `host_ready` is low while the buffer is full and for the whole length of a burst. While `host_ready` is low, the host must keep its byte and may leave `host_valid` high. Nothing offered during that time is stored.

Top module: `bsbc_burst_serializer`

## Requirements
- R1: A host byte is stored exactly when `host_valid` and `host_ready` are both high at a rising clock edge. `host_ready` is high after reset and whenever the block is idle with fewer than 16 stored words.
- R2: The buffer holds 16 words. The n-th byte accepted after a clear is the word for module n, with n counted from 0.
- R3: A burst begins only if `burst_go` is seen while all 16 words are stored. A `burst_go` seen with a partial fill is ignored: no serial clock pulse and no strobe follow, and the stored words are kept.
- R4: Each word is sent MSB first as exactly 8 serial clock pulses. Bit 7 is the power enable and bits 6:0 are the phase. The value of `ser_dat` at each rising edge of `ser_clk` is the next bit.
- R5: `ser_dat` changes only in cycles where `ser_clk` is low, so it is stable at every rising edge of `ser_clk`. Between words, `ser_clk` rests low.
- R6: `ser_stb` is high for exactly one cycle per word. It is high in the second cycle after the cycle in which the word's last `ser_clk` pulse went high.
- R7: Modules are sent in ascending order 0 to 15, with `mod_addr` equal to the module index. `mod_addr` is stable from the cycle before the word's first clock pulse through the cycle after its strobe.
- R8: `burst_done` is a one-cycle pulse in the cycle after the last module's strobe. At that point the buffer is empty and `host_ready` is high, and a new burst needs 16 fresh bytes.
- R9: Bytes offered while a burst is running are refused (`host_ready` low) and do not change the words sent.
- R10: During reset and directly after it, `mod_addr`, `ser_dat`, `ser_clk`, `ser_stb` and `burst_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast logic clock; the serial side runs from it |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host offers a command byte |
| host_ready | output | 1 | Block can accept a byte this cycle |
| host_byte | input | 8 | Command byte: bit 7 power enable, bits 6:0 phase |
| burst_go | input | 1 | Start request; acted on only with a full buffer while idle |
| mod_addr | output | 4 | Index of the module being programmed |
| ser_dat | output | 1 | Serial command data, MSB first |
| ser_clk | output | 1 | Gated serial clock, one pulse per bit |
| ser_stb | output | 1 | One-cycle load strobe after each word |
| burst_done | output | 1 | One-cycle pulse when the burst has finished |

## Verification
The bound checker enforces the bus timing on every cycle of any run. It checks that data moves only while the serial clock is low and that the strobe is one cycle wide and lands two cycles after a clock pulse. It also checks that the address does not move around clock pulses and strobes, that the host is held off while the serial clock runs, and that the done pulse follows a strobe. Other behaviours only show up across a whole scenario, and the bench covers those. They are the bit order and word contents, the ascending module order, the partial-fill start being ignored, refused writes during a burst, and the buffer clearing after a burst. The bench uses several byte patterns for this, including all zeros, all ones, alternating bits and a per-module pattern.

// File: rtl/bsbc_pkg.sv
package bsbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_STRB,
    ST_HOLD
  } seq_state_t;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bsbc_cmd_store.sv
module bsbc_cmd_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = bsbc_pkg::idx_w(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             clear,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_word,
  output logic             full
);

  logic [CW-1:0]    fill_q;
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic             take;

  assign full = (fill_q == CW'(DEPTH));
  assign take = wr_en && !full;

  always_ff @(posedge clk) begin
    if (!rst_n)      fill_q <= '0;
    else if (clear)  fill_q <= '0;
    else if (take)   fill_q <= fill_q + CW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                           slot_q[g] <= '0;
      else if (clear)                       slot_q[g] <= '0;
      else if (take && fill_q == CW'(g))    slot_q[g] <= wr_word;
    end
  end

  assign rd_word = slot_q[rd_idx];

endmodule

// File: rtl/bsbc_burst_seq.sv
module bsbc_burst_seq #(
  parameter int unsigned NUM_MOD = 16,
  parameter int unsigned WORD_W  = 8,
  localparam int unsigned AW = bsbc_pkg::idx_w(NUM_MOD),
  localparam int unsigned BW = bsbc_pkg::idx_w(WORD_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic                   full,
  output bsbc_pkg::seq_state_t   state_o,
  output logic [AW-1:0]          mod_o,
  output logic [BW-1:0]          bit_o,
  output logic                   busy,
  output logic                   last_hold
);
  import bsbc_pkg::*;

  localparam logic [BW-1:0] TOP_BIT  = BW'(WORD_W - 1);
  localparam logic [AW-1:0] LAST_MOD = AW'(NUM_MOD - 1);

  seq_state_t    st_q;
  logic [AW-1:0] mod_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      mod_q <= '0;
      bit_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go && full) begin
          st_q  <= ST_SETUP;
          mod_q <= '0;
          bit_q <= TOP_BIT;
        end
        ST_SETUP: st_q <= ST_LOW;
        ST_LOW:   st_q <= ST_HIGH;
        ST_HIGH: begin
          if (bit_q == '0) st_q <= ST_GAP;
          else begin
            bit_q <= bit_q - BW'(1);
            st_q  <= ST_LOW;
          end
        end
        ST_GAP:  st_q <= ST_STRB;
        ST_STRB: st_q <= ST_HOLD;
        ST_HOLD: begin
          if (mod_q == LAST_MOD) st_q <= ST_IDLE;
          else begin
            mod_q <= mod_q + AW'(1);
            bit_q <= TOP_BIT;
            st_q  <= ST_SETUP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = st_q;
  assign mod_o     = mod_q;
  assign bit_o     = bit_q;
  assign busy      = (st_q != ST_IDLE);
  assign last_hold = (st_q == ST_HOLD) && (mod_q == LAST_MOD);

endmodule

// File: rtl/bsbc_line_drive.sv
module bsbc_line_drive #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned AW     = 4,
  parameter int unsigned BW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bsbc_pkg::seq_state_t state_i,
  input  logic [AW-1:0]        mod_i,
  input  logic [BW-1:0]        bit_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 fin_i,
  output logic [AW-1:0]        addr_o,
  output logic                 dat_o,
  output logic                 sclk_o,
  output logic                 stb_o,
  output logic                 done_o
);
  import bsbc_pkg::*;

  logic shifting;
  assign shifting = (state_i == ST_SETUP) || (state_i == ST_LOW) || (state_i == ST_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o <= '0;
      dat_o  <= 1'b0;
      sclk_o <= 1'b0;
      stb_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      addr_o <= (state_i == ST_IDLE) ? '0 : mod_i;
      dat_o  <= shifting ? word_i[bit_i] : 1'b0;
      sclk_o <= (state_i == ST_HIGH);
      stb_o  <= (state_i == ST_STRB);
      done_o <= fin_i;
    end
  end

endmodule

// File: rtl/bsbc_burst_serializer.sv
module bsbc_burst_serializer #(
  parameter int unsigned NUM_MOD = 16,
  parameter int unsigned PHASE_W = 7,
  localparam int unsigned WORD_W = PHASE_W + 1,
  localparam int unsigned AW     = bsbc_pkg::idx_w(NUM_MOD),
  localparam int unsigned BW     = bsbc_pkg::idx_w(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [WORD_W-1:0] host_byte,
  input  logic              burst_go,
  output logic [AW-1:0]     mod_addr,
  output logic              ser_dat,
  output logic              ser_clk,
  output logic              ser_stb,
  output logic              burst_done
);

  bsbc_pkg::seq_state_t st;
  logic [AW-1:0]     cur_mod;
  logic [BW-1:0]     cur_bit;
  logic [WORD_W-1:0] cur_word;
  logic              busy, full, fin, wr_en;

  assign host_ready = !busy && !full;
  assign wr_en      = host_valid && host_ready;

  bsbc_cmd_store #(.DEPTH(NUM_MOD), .WIDTH(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (host_byte),
    .clear   (fin),
    .rd_idx  (cur_mod),
    .rd_word (cur_word),
    .full    (full)
  );

  bsbc_burst_seq #(.NUM_MOD(NUM_MOD), .WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (burst_go),
    .full      (full),
    .state_o   (st),
    .mod_o     (cur_mod),
    .bit_o     (cur_bit),
    .busy      (busy),
    .last_hold (fin)
  );

  bsbc_line_drive #(.WORD_W(WORD_W), .AW(AW), .BW(BW)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (st),
    .mod_i   (cur_mod),
    .bit_i   (cur_bit),
    .word_i  (cur_word),
    .fin_i   (fin),
    .addr_o  (mod_addr),
    .dat_o   (ser_dat),
    .sclk_o  (ser_clk),
    .stb_o   (ser_stb),
    .done_o  (burst_done)
  );

endmodule

// File: rtl/bsbc_checks.sv
module bsbc_checks #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ready,
  input logic [AW-1:0] mod_addr,
  input logic          ser_dat,
  input logic          ser_clk,
  input logic          ser_stb,
  input logic          burst_done
);

  // R5
  dat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dat) |-> !ser_clk);

  // R6
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |=> !ser_stb);

  // R6
  stb_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |-> ($past(ser_clk, 2) && !$past(ser_clk, 1)));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk || ser_stb || $fell(ser_stb)) |-> $stable(mod_addr));

  // R9
  no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk || ser_stb) |-> !host_ready);

  // R8
  done_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> ($past(ser_stb) && host_ready));

  // R8
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

endmodule

bind bsbc_burst_serializer bsbc_checks #(.AW(AW)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .mod_addr   (mod_addr),
  .ser_dat    (ser_dat),
  .ser_clk    (ser_clk),
  .ser_stb    (ser_stb),
  .burst_done (burst_done)
);

// File: tb/tb_bsbc_burst_serializer.sv
`timescale 1ns/1ps
module tb_bsbc_burst_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0;
  logic       host_ready;
  logic [7:0] host_byte = '0;
  logic       burst_go = 1'b0;
  logic [3:0] mod_addr;
  logic       ser_dat, ser_clk, ser_stb, burst_done;

  always #4 clk = ~clk;

  bsbc_burst_serializer dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_byte(host_byte), .burst_go(burst_go), .mod_addr(mod_addr),
    .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_stb(ser_stb), .burst_done(burst_done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor, sampled away from the active edge
  logic       p_clk = 0, p_dat = 0, p_stb = 0;
  logic [3:0] p_addr = 0, w_addr = 0;
  logic [7:0] shreg = 0;
  int rise_cnt = 0, rises = 0, since = 99, stb_cnt = 0, done_cnt = 0;
  int err_t = 0, err_a = 0, err_d = 0;
  logic [7:0] cap_w [16];
  logic [3:0] cap_a [16];

  always @(negedge clk) if (rst_n) begin
    if (ser_clk && !p_clk) begin
      rises++;
      if (rise_cnt == 0) begin
        if (mod_addr != p_addr) err_a++;
        w_addr = mod_addr;
      end else if (mod_addr != w_addr) err_a++;
      if (ser_dat != p_dat) err_d++;
      shreg = {shreg[6:0], ser_dat};
      rise_cnt++;
      since = 0;
    end else if (since < 99) since++;
    if (ser_clk && (ser_dat != p_dat)) err_d++;
    if (ser_stb) begin
      if (since != 2 || rise_cnt != 8 || p_stb) err_t++;
      if (mod_addr != w_addr) err_a++;
      if (stb_cnt < 16) begin
        cap_w[stb_cnt] = shreg;
        cap_a[stb_cnt] = mod_addr;
      end
      stb_cnt++;
      rise_cnt = 0;
    end
    if (p_stb && mod_addr != p_addr) err_a++;
    if (burst_done) begin
      done_cnt++;
      if (!p_stb) err_t++;
    end
    p_clk = ser_clk; p_dat = ser_dat; p_stb = ser_stb; p_addr = mod_addr;
  end

  task automatic mon_clear();
    rise_cnt = 0; rises = 0; stb_cnt = 0; done_cnt = 0;
    err_t = 0; err_a = 0; err_d = 0; since = 99;
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    case (k)
      0: return 8'(i * 29 + 3);
      1: return 8'h00;
      2: return 8'hFF;
      3: return (i % 2 == 1) ? 8'h5A : 8'hA5;
      default: return {i[0], 3'b010, i[3:0]};
    endcase
  endfunction

  task automatic push(input logic [7:0] d, output bit ok);
    @(negedge clk);
    host_valid = 1'b1;
    host_byte  = d;
    ok = host_ready;
    @(posedge clk);
  endtask

  task automatic fill(input int k, input int lo, input int hi, input string tag);
    int acc = 0;
    bit ok;
    for (int i = lo; i <= hi; i++) begin
      push(pat(k, i), ok);
      if (ok) acc++;
    end
    @(negedge clk);
    host_valid = 1'b0;
    chk(acc == hi - lo + 1, {tag, " R1 bytes accepted"}, acc, hi - lo + 1);
  endtask

  task automatic go_pulse();
    @(negedge clk); burst_go = 1'b1;
    @(negedge clk); burst_go = 1'b0;
  endtask

  task automatic wait_done_and_check(input int k, input string tag);
    int n = 0;
    while (done_cnt == 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {tag, " R8 one done pulse"}, done_cnt, 1);
    chk(host_ready == 1'b1, {tag, " R8 ready after done"}, host_ready, 1);
    chk(stb_cnt == 16, {tag, " R6 strobe count"}, stb_cnt, 16);
    chk(rises == 128, {tag, " R4 clock pulse count"}, rises, 128);
    chk(err_t == 0, {tag, " R6 strobe timing"}, err_t, 0);
    chk(err_a == 0, {tag, " R7 address stability"}, err_a, 0);
    chk(err_d == 0, {tag, " R5 data stable at rise"}, err_d, 0);
    for (int i = 0; i < 16; i++) begin
      chk(cap_w[i] == pat(k, i), {tag, " R2 R4 word by module"}, cap_w[i], pat(k, i));
      chk(cap_a[i] == 4'(i), {tag, " R7 module order"}, cap_a[i], i);
    end
  endtask

  task automatic t_reset();
    chk(host_ready == 1'b1, "R10 ready out of reset", host_ready, 1);
    chk({mod_addr, ser_dat, ser_clk, ser_stb, burst_done} == 8'h00,
        "R10 outputs low", {mod_addr, ser_dat, ser_clk, ser_stb, burst_done}, 0);
  endtask

  task automatic t_partial_go();
    mon_clear();
    fill(0, 0, 4, "partial");
    go_pulse();
    repeat (40) @(negedge clk);
    chk(rises == 0 && stb_cnt == 0, "R3 start ignored with partial fill", rises + stb_cnt, 0);
    chk(host_ready == 1'b1, "R3 still accepting", host_ready, 1);
    fill(0, 5, 15, "complete");
    chk(host_ready == 1'b0, "R1 ready low when full", host_ready, 0);
    go_pulse();
    wait_done_and_check(0, "kept words");
  endtask

  task automatic t_pattern(input int k, input string tag);
    mon_clear();
    fill(k, 0, 15, tag);
    go_pulse();
    wait_done_and_check(k, tag);
  endtask

  task automatic t_refuse_during_burst();
    int acc = 0;
    bit ok;
    mon_clear();
    fill(4, 0, 15, "refuse");
    go_pulse();
    repeat (5) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      push(8'hC3, ok);
      if (ok) acc++;
    end
    @(negedge clk);
    host_valid = 1'b0;
    chk(acc == 0, "R9 writes refused during burst", acc, 0);
    wait_done_and_check(4, "refuse");
  endtask

  task automatic t_clear_after_done();
    mon_clear();
    fill(2, 0, 14, "refill");
    go_pulse();
    repeat (40) @(negedge clk);
    chk(rises == 0 && stb_cnt == 0, "R8 buffer cleared, 15 words no burst", rises + stb_cnt, 0);
    fill(2, 15, 15, "refill last");
    go_pulse();
    wait_done_and_check(2, "refill");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_partial_go();
    t_pattern(1, "zeros");
    t_pattern(2, "ones");
    t_pattern(3, "alternating");
    t_refuse_during_burst();
    t_clear_after_done();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule